// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block holds the atomic reservation of one processor. A load-locked request records the aligned block that holds its address. A later store-conditional request is then judged against that record. The store reaches memory only if three things are true: the reservation is still live, the store falls in the same block, and nothing broke the sequence in the meantime. Software uses it in a loop: load-locked, change the value in a register, store-conditional, then test the returned status and start again on failure.

Any of the following breaks the reservation:
- an interrupt;
- an exception;
- a store by another agent that hits the reserved block, seen on one of the snoop ports.

Every store-conditional also ends the reservation, whether it commits or not. The decision is combinational, so it appears in the same cycle as the store-conditional request. The status word (1 for success, 0 for failure) is returned in that cycle, to be written back into the register that supplied the store data.

Top module: `llsc_resv_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with no requests, `resv_valid`, `mem_we` and `status_valid` are 0.
- R2: A load-locked request in a cycle with no interrupt, no exception and no store-conditional sets `resv_valid` from the next cycle. It records address bits [ADDR_W-1:GRAN_LOG2], which are bits [63:4] by default.
- R3: A store-conditional commits (`mem_we`=1 in the same cycle, with `mem_addr`=`sc_addr` and `mem_wdata`=`sc_data`) only if `resv_valid` is 1 and `sc_addr` lies in the reserved block. The low GRAN_LOG2 address bits are ignored in the comparison.
- R4: An interrupt (`irq_event`) clears the reservation from the next cycle. A store-conditional in the same cycle as an interrupt fails.
- R5: An exception (`exc_event`) clears the reservation from the next cycle. A store-conditional in the same cycle as an exception fails.
- R6: A valid snoop on any port whose address lies in the reserved block clears the reservation from the next cycle, and a store-conditional in that same cycle fails. A snoop to another block has no effect.
- R7: `status_valid` equals `sc_valid`. `status_value` is 1 when the store-conditional commits and 0 when it fails, and it is 0 when no store-conditional is present.
- R8: Every store-conditional clears the reservation from the next cycle, whether it succeeds or fails.
- R9: A load-locked replaces any earlier reservation. The priority order is: interrupt or exception, then store-conditional, then load-locked, then snoop. A load-locked in the same cycle as any higher-priority event leaves `resv_valid` at 0.
- R10: `mem_we` is never 1 unless `sc_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-locked request |
| ll_addr | input | ADDR_W | Load-locked byte address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| sc_data | input | DATA_W | Store-conditional data |
| irq_event | input | 1 | Interrupt taken this cycle |
| exc_event | input | 1 | Exception raised this cycle |
| snoop_valid | input | SNOOP_PORTS | Store by another agent, one bit per port |
| snoop_addr | input | SNOOP_PORTS*ADDR_W | Snooped store addresses, port 0 in the low bits |
| mem_we | output | 1 | Memory write enable for a committing store |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| status_valid | output | 1 | Status word is to be written back |
| status_value | output | DATA_W | 1 on success, 0 on failure |
| resv_valid | output | 1 | Reservation live |

## Verification
The assertions assume that an interrupt or exception is a single-cycle pulse seen by the monitor in the cycle it is taken. They also assume that snoop bits are meaningful only in cycles where they are valid. The stimulus keeps to this by drawing every request bit independently each cycle. Addresses come from a small pool that mixes offsets inside one block with neighbouring blocks, so that matches, near misses and same-cycle collisions between load-locked, store-conditional, snoop and interrupt all occur often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      RSV_HOLD = 2'd0,
      RSV_KILL = 2'd1,
      RSV_DROP = 2'd2,
      RSV_LOAD = 2'd3
   } rsv_op_e;

   function automatic rsv_op_e pick_op(input logic brk, input logic sc,
                                       input logic ll, input logic snp);
      if (brk)      return RSV_KILL;
      else if (sc)  return RSV_DROP;
      else if (ll)  return RSV_LOAD;
      else if (snp) return RSV_KILL;
      return RSV_HOLD;
   endfunction
endpackage

// File: rtl/llsc_blk_match.sv
module llsc_blk_match #(
   parameter int ADDR_W    = 64,
   parameter int GRAN_LOG2 = 4,
   localparam int TAG_W    = ADDR_W - GRAN_LOG2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [TAG_W-1:0]  tag,
   output logic              hit
);
   always_comb hit = (addr[ADDR_W-1:GRAN_LOG2] == tag);
endmodule

// File: rtl/llsc_snoop_filter.sv
module llsc_snoop_filter #(
   parameter int ADDR_W      = 64,
   parameter int GRAN_LOG2   = 4,
   parameter int SNOOP_PORTS = 2,
   localparam int TAG_W      = ADDR_W - GRAN_LOG2
) (
   input  logic [SNOOP_PORTS-1:0]        snp_valid,
   input  logic [SNOOP_PORTS*ADDR_W-1:0] snp_addr,
   input  logic [TAG_W-1:0]              tag,
   output logic                          any_hit
);
   logic [SNOOP_PORTS-1:0] port_hit;

   for (genvar p = 0; p < SNOOP_PORTS; p++) begin : g_port
      logic match;
      llsc_blk_match #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_cmp (
         .addr (snp_addr[p*ADDR_W +: ADDR_W]),
         .tag  (tag),
         .hit  (match)
      );
      always_comb port_hit[p] = snp_valid[p] & match;
   end

   always_comb any_hit = |port_hit;
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg
   import llsc_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int GRAN_LOG2 = 4,
   localparam int TAG_W    = ADDR_W - GRAN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rsv_op_e           op,
   input  logic [ADDR_W-1:0] load_addr,
   output logic              valid_q,
   output logic [TAG_W-1:0]  tag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
      end else begin
         unique case (op)
            RSV_HOLD: valid_q <= valid_q;
            RSV_KILL: valid_q <= 1'b0;
            RSV_DROP: valid_q <= 1'b0;
            RSV_LOAD: begin
               valid_q <= 1'b1;
               tag_q   <= load_addr[ADDR_W-1:GRAN_LOG2];
            end
            default:  valid_q <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
   import llsc_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int DATA_W      = 64,
   parameter int GRAN_LOG2   = 4,
   parameter int SNOOP_PORTS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ll_valid,
   input  logic [ADDR_W-1:0]             ll_addr,
   input  logic                          sc_valid,
   input  logic [ADDR_W-1:0]             sc_addr,
   input  logic [DATA_W-1:0]             sc_data,
   input  logic                          irq_event,
   input  logic                          exc_event,
   input  logic [SNOOP_PORTS-1:0]        snoop_valid,
   input  logic [SNOOP_PORTS*ADDR_W-1:0] snoop_addr,
   output logic                          mem_we,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [DATA_W-1:0]             mem_wdata,
   output logic                          status_valid,
   output logic [DATA_W-1:0]             status_value,
   output logic                          resv_valid
);
   localparam int TAG_W = ADDR_W - GRAN_LOG2;

   if (GRAN_LOG2 < 0 || GRAN_LOG2 >= ADDR_W) begin : g_bad_gran
      $error("GRAN_LOG2 must lie in [0, ADDR_W)");
   end
   if (SNOOP_PORTS < 1) begin : g_bad_ports
      $error("SNOOP_PORTS must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic             valid_q;
   logic [TAG_W-1:0] tag_q;
   logic             sc_in_blk;
   logic             snp_hit;
   logic             brk;
   logic             commit;
   rsv_op_e          op;

   llsc_blk_match #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_sc_cmp (
      .addr (sc_addr),
      .tag  (tag_q),
      .hit  (sc_in_blk)
   );

   llsc_snoop_filter #(
      .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .SNOOP_PORTS(SNOOP_PORTS)
   ) u_snoop (
      .snp_valid (snoop_valid),
      .snp_addr  (snoop_addr),
      .tag       (tag_q),
      .any_hit   (snp_hit)
   );

   always_comb begin
      brk    = irq_event | exc_event;
      commit = sc_valid & valid_q & sc_in_blk & ~brk & ~snp_hit;
      op     = pick_op(brk, sc_valid, ll_valid, valid_q & snp_hit);
   end

   llsc_resv_reg #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_resv (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .load_addr (ll_addr),
      .valid_q   (valid_q),
      .tag_q     (tag_q)
   );

   always_comb begin
      mem_we       = commit;
      mem_addr     = sc_addr;
      mem_wdata    = sc_data;
      status_valid = sc_valid;
      status_value = '0;
      status_value[0] = commit;
      resv_valid   = valid_q;
   end
endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ll_valid,
   input logic              sc_valid,
   input logic              irq_event,
   input logic              exc_event,
   input logic              mem_we,
   input logic              status_valid,
   input logic [DATA_W-1:0] status_value,
   input logic              resv_valid
);
   a_r10_we_needs_sc: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> sc_valid);
   a_r3_we_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> resv_valid);
   a_r4_irq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      irq_event |-> !mem_we);
   a_r4_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
      irq_event |=> !resv_valid);
   a_r5_exc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      exc_event |-> !mem_we);
   a_r5_exc_clears: assert property (@(posedge clk) disable iff (!rst_n)
      exc_event |=> !resv_valid);
   a_r8_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sc_valid |=> !resv_valid);
   a_r2_ll_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_valid && !sc_valid && !irq_event && !exc_event) |=> resv_valid);
   a_r7_status_word: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> (status_value == DATA_W'(mem_we)));
   a_r7_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !status_valid |-> (status_value == '0));
endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ll_valid     (ll_valid),
   .sc_valid     (sc_valid),
   .irq_event    (irq_event),
   .exc_event    (exc_event),
   .mem_we       (mem_we),
   .status_valid (status_valid),
   .status_value (status_value),
   .resv_valid   (resv_valid)
);

// File: tb/llsc_resv_monitor_bench.sv
module llsc_resv_monitor_bench;
   localparam int AW = 64;
   localparam int DW = 64;
   localparam int NP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ll_valid = 1'b0, sc_valid = 1'b0, irq_event = 1'b0, exc_event = 1'b0;
   logic [AW-1:0] ll_addr = '0, sc_addr = '0;
   logic [DW-1:0] sc_data = '0;
   logic [NP-1:0] snoop_valid = '0;
   logic [NP*AW-1:0] snoop_addr = '0;
   logic          mem_we, status_valid, resv_valid;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, status_value;

   int checks = 0;
   int errors = 0;

   bit            m_valid = 0;
   bit [AW-5:0]   m_tag = '0;

   always #5 clk = ~clk;

   llsc_resv_monitor #(.ADDR_W(AW), .DATA_W(DW), .GRAN_LOG2(4), .SNOOP_PORTS(NP))
   u_llsc_resv_monitor (
      .clk(clk), .rst_n(rst_n), .ll_valid(ll_valid), .ll_addr(ll_addr),
      .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_data(sc_data),
      .irq_event(irq_event), .exc_event(exc_event),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .status_valid(status_valid), .status_value(status_value),
      .resv_valid(resv_valid)
   );

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // one cycle: apply inputs, compare against the model, advance the model
   task automatic step(input string tag, input bit ll, input logic [AW-1:0] la,
                       input bit sc, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input bit irq, input bit exc,
                       input logic [NP-1:0] sv, input logic [NP*AW-1:0] sad);
      bit snp, brk, ok;
      string t;
      @(negedge clk);
      chk(tag == "" ? "R9" : tag, "resv_valid", 128'(resv_valid), 128'(m_valid));
      ll_valid = ll; ll_addr = la; sc_valid = sc; sc_addr = sa; sc_data = sd;
      irq_event = irq; exc_event = exc; snoop_valid = sv; snoop_addr = sad;
      snp = 0;
      for (int p = 0; p < NP; p++)
         if (sv[p] && sad[p*AW+4 +: AW-4] == m_tag) snp = 1;
      brk = irq | exc;
      ok  = sc && m_valid && (sa[AW-1:4] == m_tag) && !brk && !snp;
      t = tag;
      if (t == "") t = irq ? "R4" : exc ? "R5" : (snp && m_valid) ? "R6" : sc ? "R3" : "R10";
      #3;
      chk(t, "mem_we", 128'(mem_we), 128'(ok));
      if (ok) begin
         chk("R3", "mem_addr", 128'(mem_addr), 128'(sa));
         chk("R3", "mem_wdata", 128'(mem_wdata), 128'(sd));
      end
      chk("R7", "status_valid", 128'(status_valid), 128'(sc));
      chk("R7", "status_value", 128'(status_value), 128'(ok));
      @(posedge clk);
      if (brk) m_valid = 0;
      else if (sc) m_valid = 0;
      else if (ll) begin m_valid = 1; m_tag = la[AW-1:4]; end
      else if (snp && m_valid) m_valid = 0;
   endtask

   task automatic idle(input string tag);
      step(tag, 0, '0, 0, '0, '0, 0, 0, '0, '0);
   endtask

   localparam logic [AW-1:0] A = 64'h0000_0000_0000_1000;
   localparam logic [AW-1:0] B = 64'h0000_0000_0000_1010;
   localparam logic [AW-1:0] C = 64'h0000_0000_0000_2000;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "resv_valid in reset", 128'(resv_valid), 0);
      chk("R1", "mem_we in reset", 128'(mem_we), 0);
      chk("R1", "status_valid in reset", 128'(status_valid), 0);
      rst_n = 1'b1;
      idle("R1");
      // R2/R3/R7/R8: success with an offset inside the block
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R3", 0, '0, 1, A + 8, 64'hDEAD_BEEF_0123_4567, 0, 0, '0, '0);
      idle("R8");
      // R3: other block fails; R8: failed store still clears
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R3", 0, '0, 1, B, 64'h11, 0, 0, '0, '0);
      step("R8", 0, '0, 1, A, 64'h12, 0, 0, '0, '0);
      // R4: interrupt while held, and in the same cycle as the store
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R4", 0, '0, 0, '0, '0, 1, 0, '0, '0);
      step("R4", 0, '0, 1, A, 64'h21, 0, 0, '0, '0);
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R4", 0, '0, 1, A, 64'h22, 1, 0, '0, '0);
      // R5: exception
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R5", 0, '0, 0, '0, '0, 0, 1, '0, '0);
      step("R5", 0, '0, 1, A, 64'h31, 0, 0, '0, '0);
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R5", 0, '0, 1, A, 64'h32, 0, 1, '0, '0);
      // R6: snoop to another block is harmless, to the block clears
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R6", 0, '0, 0, '0, '0, 0, 0, 2'b11, {C, B});
      step("R6", 0, '0, 1, A + 4, 64'h41, 0, 0, '0, '0);
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R6", 0, '0, 0, '0, '0, 0, 0, 2'b10, {A + 12, C});
      step("R6", 0, '0, 1, A, 64'h42, 0, 0, '0, '0);
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R6", 0, '0, 1, A, 64'h43, 0, 0, 2'b01, {C, A});
      // R9: replacement and priority
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R9", 1, C, 0, '0, '0, 0, 0, '0, '0);
      step("R9", 0, '0, 1, A, 64'h51, 0, 0, '0, '0);
      step("R2", 1, A, 0, '0, '0, 0, 0, '0, '0);
      step("R9", 1, C, 0, '0, '0, 0, 0, '0, '0);
      step("R9", 0, '0, 1, C + 4, 64'h52, 0, 0, '0, '0);
      step("R9", 1, A, 0, '0, '0, 1, 0, '0, '0);
      step("R9", 1, A, 1, A, 64'h53, 0, 0, '0, '0);
      step("R2", 1, A, 0, '0, '0, 0, 0, 2'b01, {C, A});
      idle("R9");
      step("R10", 0, '0, 0, A, '0, 0, 0, '0, '0);
      // mixed random traffic over a small address pool
      for (int i = 0; i < 4000; i++) begin
         logic [AW-1:0] pool [4];
         logic [NP*AW-1:0] sad;
         pool[0] = A; pool[1] = A + 8; pool[2] = B; pool[3] = C;
         for (int p = 0; p < NP; p++) sad[p*AW +: AW] = pool[$urandom_range(3)];
         step("", ($urandom_range(2) == 0), pool[$urandom_range(3)],
              ($urandom_range(3) == 0), pool[$urandom_range(3)], {$urandom, $urandom},
              ($urandom_range(15) == 0), ($urandom_range(15) == 0),
              NP'($urandom_range(7) == 0 ? $urandom : 0), sad);
      end
      idle("R9");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule